// File: doc/BRIEF.md
# Dual-Plane Pixel Source Selector

This block is one stage of a display scan-out path. For every pixel it receives three words fetched from three side-by-side frame planes: an 8-bit palette index, a 32-bit direct-colour word and a 32-bit control word. The most significant byte of the control word is a tag. When the tag carries the "direct" code, the pixel shows the 24-bit colour held in the direct word. For any other tag, the pixel shows the palette colour that the index selects.

Pixels arrive on a valid/ready stream. The block drives a synchronous read port into an external 256-entry colour table and emits a 24-bit RGB stream with a valid flag that honours backpressure. The palette answers one cycle after it is addressed, so the decision and the direct colour travel one register stage behind the read. A second register stage forms the output. A stall on the output freezes both stages, and no pixel is dropped.

A small capture register keeps the palette answer while the middle stage is stalled. As a result, the table's read data may change freely on any cycle in which the block did not issue a read.

Top module: `dual_plane_pixsel`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is low and `in_ready` is high.
- R2: A pixel whose control word has bits 31:24 equal to 0x03 is output as direct colour: red = direct[23:16], green = direct[15:8], blue = direct[7:0]. The output carries red in out_rgb[23:16], green in [15:8] and blue in [7:0].
- R3: For a direct pixel, bits 31:24 of the direct word and the palette index have no effect on the output colour.
- R4: A pixel with any other tag (for example 0x00, 0x02, 0x83, 0xFF) is output as the palette entry at its index, for every index from 0 to 255. The palette data uses the same red/green/blue layout as out_rgb. Control bits 23:0 have no effect.
- R5: `pal_rd_en` is high exactly in the cycles in which a pixel is accepted (`in_valid` and `in_ready`), and `pal_rd_addr` then equals that pixel's index. The palette returns data in the following cycle.
- R6: A pixel accepted at clock edge k is presented with `out_valid` high after edge k+1 (two-cycle latency).
- R7: Pixels leave in the order they were accepted, none is lost or duplicated, and with `out_ready` held high the block accepts one pixel per cycle.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_rgb` and `out_valid` hold their values into the next cycle.
- R9: A palette pixel stalled in the middle stage outputs the colour read at its acceptance, even if `pal_rd_data` changes in the cycles after that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block accepts the input pixel this cycle |
| in_index | input | 8 | Palette index plane value |
| in_ctrl | input | 32 | Control plane word; tag in bits 31:24 |
| in_direct | input | 32 | Direct-colour plane word; colour in bits 23:0 |
| pal_rd_en | output | 1 | Palette read strobe |
| pal_rd_addr | output | 8 | Palette read address |
| pal_rd_data | input | 24 | Palette entry, valid one cycle after the read |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_rgb | output | 24 | Output colour {red, green, blue} |

## Verification
The assertions watch the stream contract on every cycle. They check that output stays frozen and input is refused under backpressure, that an accepted pixel always reaches the output two edges later, that at most two pixels are ever in flight, and that no output handshake occurs without a pending pixel. Colour correctness cannot be seen by those properties. It comes from the bench's scenarios, which compare each output against a reference model across direct tags, non-direct tags (including 0x02 and 0x83), both extreme indices, and ignored bits. A palette model that returns junk whenever it was not just read is what exposes a missing capture register during long stalls.

// File: rtl/dps_pkg.sv
`timescale 1ns/1ps
package dps_pkg;

    localparam int CHAN_W = 8;
    localparam int RGB_W  = 3 * CHAN_W;
    localparam int WORD_W = 32;
    localparam int TAG_W  = 8;

    typedef struct packed {
        logic [CHAN_W-1:0] r;
        logic [CHAN_W-1:0] g;
        logic [CHAN_W-1:0] b;
    } rgb_t;

    typedef enum logic {
        SRC_PALETTE = 1'b0,
        SRC_DIRECT  = 1'b1
    } src_e;

    typedef struct packed {
        src_e src;
        rgb_t direct;
    } sel_t;

    function automatic logic [TAG_W-1:0] tag_of(input logic [WORD_W-1:0] ctrl);
        return ctrl[WORD_W-1 -: TAG_W];
    endfunction

    function automatic rgb_t direct_colour(input logic [WORD_W-1:0] word);
        rgb_t c;
        c.r = word[3*CHAN_W-1 -: CHAN_W];
        c.g = word[2*CHAN_W-1 -: CHAN_W];
        c.b = word[CHAN_W-1 -: CHAN_W];
        return c;
    endfunction

endpackage

// File: rtl/dps_tag_decode.sv
`timescale 1ns/1ps
module dps_tag_decode
    import dps_pkg::*;
#(
    parameter logic [TAG_W-1:0] DIRECT_TAG = 8'h03
) (
    input  logic [WORD_W-1:0] ctrl,
    input  logic [WORD_W-1:0] direct,
    output sel_t              sel
);
    logic unused_bits;
    assign unused_bits = ^{ctrl[WORD_W-TAG_W-1:0], direct[WORD_W-1:RGB_W]};

    always_comb begin
        sel.src    = (tag_of(ctrl) == DIRECT_TAG) ? SRC_DIRECT : SRC_PALETTE;
        sel.direct = direct_colour(direct);
    end
endmodule

// File: rtl/dps_pipe_reg.sv
`timescale 1ns/1ps
module dps_pipe_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         vin,
    input  logic [W-1:0] din,
    output logic         vout,
    output logic [W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vout <= 1'b0;
            dout <= '0;
        end else if (en) begin
            vout <= vin;
            if (vin) dout <= din;
        end
    end
endmodule

// File: rtl/dps_pal_hold.sv
`timescale 1ns/1ps
module dps_pal_hold
    import dps_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_issued,
    input  rgb_t rd_data,
    output rgb_t colour
);
    logic fresh;
    rgb_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            fresh <= 1'b0;
            held  <= '0;
        end else begin
            fresh <= rd_issued;
            if (fresh) held <= rd_data;
        end
    end

    assign colour = fresh ? rd_data : held;
endmodule

// File: rtl/dual_plane_pixsel.sv
`timescale 1ns/1ps
module dual_plane_pixsel
    import dps_pkg::*;
#(
    parameter int               IDX_W      = 8,
    parameter logic [TAG_W-1:0] DIRECT_TAG = 8'h03
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [IDX_W-1:0]  in_index,
    input  logic [WORD_W-1:0] in_ctrl,
    input  logic [WORD_W-1:0] in_direct,
    output logic              pal_rd_en,
    output logic [IDX_W-1:0]  pal_rd_addr,
    input  logic [RGB_W-1:0]  pal_rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [RGB_W-1:0]  out_rgb
);
    localparam int SEL_W = $bits(sel_t);

    logic advance;
    logic accept;
    sel_t sel_in;
    sel_t sel_mid;
    logic [SEL_W-1:0] sel_mid_raw;
    logic mid_valid;
    rgb_t pal_colour;
    rgb_t chosen;

    // whole pipeline moves together; it moves whenever the output slot frees
    assign advance  = !out_valid || out_ready;
    assign in_ready = advance;
    assign accept   = in_valid && advance;

    assign pal_rd_en   = accept;
    assign pal_rd_addr = in_index;

    dps_tag_decode #(.DIRECT_TAG(DIRECT_TAG)) u_decode (
        .ctrl   (in_ctrl),
        .direct (in_direct),
        .sel    (sel_in)
    );

    dps_pipe_reg #(.W(SEL_W)) u_mid (
        .clk  (clk),
        .rst  (rst),
        .en   (advance),
        .vin  (in_valid),
        .din  (sel_in),
        .vout (mid_valid),
        .dout (sel_mid_raw)
    );
    assign sel_mid = sel_t'(sel_mid_raw);

    dps_pal_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .rd_issued (accept),
        .rd_data   (rgb_t'(pal_rd_data)),
        .colour    (pal_colour)
    );

    assign chosen = (sel_mid.src == SRC_DIRECT) ? sel_mid.direct : pal_colour;

    dps_pipe_reg #(.W(RGB_W)) u_out (
        .clk  (clk),
        .rst  (rst),
        .en   (advance),
        .vin  (mid_valid),
        .din  (chosen),
        .vout (out_valid),
        .dout (out_rgb)
    );
endmodule

// File: rtl/dps_chk.sv
`timescale 1ns/1ps
module dps_chk
    import dps_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [RGB_W-1:0] out_rgb
);
    logic [2:0] inflight;
    logic       acc;
    logic       emit;

    assign acc  = in_valid && in_ready;
    assign emit = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) inflight <= '0;
        else     inflight <= inflight + {2'b0, acc} - {2'b0, emit};
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> !out_valid);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb)));

    // R8
    stall_block_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R6
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        acc |=> ##1 out_valid);

    // R7
    inflight_bound_chk: assert property (@(posedge clk) disable iff (rst)
        inflight <= 3'd2);

    // R7
    no_phantom_chk: assert property (@(posedge clk) disable iff (rst)
        emit |-> (inflight != 3'd0));
endmodule

bind dual_plane_pixsel dps_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_rgb   (out_rgb)
);

// File: tb/sim_dual_plane_pixsel.sv
`timescale 1ns/1ps
module sim_dual_plane_pixsel;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [7:0]  in_index;
    logic [31:0] in_ctrl;
    logic [31:0] in_direct;
    logic        pal_rd_en;
    logic [7:0]  pal_rd_addr;
    logic [23:0] pal_rd_data;
    logic        out_valid;
    logic        out_ready;
    logic [23:0] out_rgb;

    always #10 clk = ~clk;

    dual_plane_pixsel u0 (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_index    (in_index),
        .in_ctrl     (in_ctrl),
        .in_direct   (in_direct),
        .pal_rd_en   (pal_rd_en),
        .pal_rd_addr (pal_rd_addr),
        .pal_rd_data (pal_rd_data),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_rgb     (out_rgb)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // palette model: answers the cycle after a read, junk otherwise
    logic [23:0] pal_mem [256];
    logic [23:0] pal_q;
    logic        pal_fresh;

    initial begin
        for (int i = 0; i < 256; i++)
            pal_mem[i] = {i[7:0], ~i[7:0], i[7:0] ^ 8'h5A};
        pal_q     = '0;
        pal_fresh = 1'b0;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        pal_fresh <= pal_rd_en;
        if (pal_rd_en) pal_q <= pal_mem[pal_rd_addr];
    end

    assign pal_rd_data = pal_fresh ? pal_q : (24'hC3A55A ^ 24'(cyc * 40503));

    logic [7:0]  st_idx [64];
    logic [31:0] st_ctrl[64];
    logic [31:0] st_dir [64];
    logic [23:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] ref_px(input logic [7:0] idx,
                                           input logic [31:0] ctrl,
                                           input logic [31:0] dir);
        if (ctrl[31:24] == 8'h03) return dir[23:0];
        return pal_mem[idx];
    endfunction

    function automatic bit pat(input int m, input int c);
        case (m)
            0: return 1'b1;
            1: return (c % 2) == 0;
            2: return ((c * 13 + 5) % 7) < 4;
            default: return ((c * 29 + 3) % 11) < 3;
        endcase
    endfunction

    task automatic run_stream(input int n, input int vmode, input int rmode,
                              input string req, output int cycles);
        int sent = 0;
        int got = 0;
        int guard = 0;
        bit stalled = 1'b0;
        logic [23:0] held = '0;
        logic [23:0] e;
        while ((sent < n || got < n) && guard < 3000) begin
            in_valid = (sent < n) && pat(vmode, cyc);
            if (sent < n) begin
                in_index  = st_idx[sent];
                in_ctrl   = st_ctrl[sent];
                in_direct = st_dir[sent];
            end
            out_ready = pat(rmode, cyc + 7);
            #1;
            if (stalled)
                chk(out_valid && out_rgb == held, "R8", "held output", {8'h0, out_rgb}, {8'h0, held});
            if (out_valid && out_ready) begin
                got++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected output", {8'h0, out_rgb}, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    chk(out_rgb == e, req, "pixel colour", {8'h0, out_rgb}, {8'h0, e});
                end
            end
            if (in_valid) begin
                chk(pal_rd_en == in_ready, "R5", "read strobe", {31'h0, pal_rd_en}, {31'h0, in_ready});
                if (in_ready) begin
                    chk(pal_rd_addr == in_index, "R5", "read address", {24'h0, pal_rd_addr}, {24'h0, in_index});
                    exp_q.push_back(ref_px(in_index, in_ctrl, in_direct));
                    sent++;
                end
            end else begin
                chk(!pal_rd_en, "R5", "idle read strobe", {31'h0, pal_rd_en}, 32'h0);
            end
            stalled = out_valid && !out_ready;
            held    = out_rgb;
            if (stalled) chk(!in_ready, "R8", "input refused in stall", {31'h0, in_ready}, 32'h0);
            @(negedge clk);
            guard++;
        end
        in_valid  = 1'b0;
        out_ready = 1'b1;
        chk(got == n, "R7", "pixel count", got, n);
        cycles = guard;
    endtask

    task automatic t_reset();
        #1;
        chk(out_valid == 1'b0, "R1", "out_valid after reset", {31'h0, out_valid}, 32'h0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", {31'h0, in_ready}, 32'h1);
        @(negedge clk);
    endtask

    task automatic t_direct();
        int c;
        for (int i = 0; i < 24; i++) begin
            st_idx[i]  = 8'(i * 11);
            st_ctrl[i] = {8'h03, 24'(i * 12345)};
            st_dir[i]  = {8'(i * 53 + 1), 24'(i * 32'h0A1B2C + 7)};
        end
        run_stream(24, 0, 0, "R2 R3", c);
    endtask

    task automatic t_palette();
        logic [7:0] tags[8] = '{8'h00, 8'h02, 8'h83, 8'hFF, 8'h04, 8'h01, 8'h13, 8'h30};
        int c;
        for (int i = 0; i < 32; i++) begin
            st_ctrl[i] = {tags[i % 8], 24'h000003 ^ 24'(i)};
            st_idx[i]  = (i == 0) ? 8'd0 : (i == 1) ? 8'd255 : 8'(i * 71);
            st_dir[i]  = 32'h03FF_FFFF ^ 32'(i);
        end
        run_stream(32, 0, 1, "R4", c);
    endtask

    task automatic t_mixed(input int vmode, input int rmode, input string req);
        int c;
        for (int i = 0; i < 48; i++) begin
            st_ctrl[i] = {(i % 3 == 0) ? 8'h03 : (i % 3 == 1) ? 8'h83 : 8'h02, 24'(i * 777)};
            st_idx[i]  = 8'(i * 97 + 3);
            st_dir[i]  = {8'(i), 24'(i * 32'h010203 + 32'h405060)};
        end
        run_stream(48, vmode, rmode, req, c);
    endtask

    task automatic t_throughput();
        int c;
        for (int i = 0; i < 16; i++) begin
            st_ctrl[i] = {(i % 2 == 0) ? 8'h03 : 8'h02, 24'h0};
            st_idx[i]  = 8'(255 - i);
            st_dir[i]  = 32'(i * 32'h00111111);
        end
        run_stream(16, 0, 0, "R7", c);
        chk(c == 18, "R7", "cycles for 16 back-to-back pixels", c, 18);
    endtask

    task automatic t_latency();
        logic [23:0] e;
        in_index  = 8'd200;
        in_ctrl   = 32'h0200_0000;
        in_direct = 32'h0012_3456;
        in_valid  = 1'b1;
        out_ready = 1'b1;
        e = pal_mem[200];
        #1;
        chk(in_ready == 1'b1, "R6", "accepted", {31'h0, in_ready}, 32'h1);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R6", "not yet valid after one edge", {31'h0, out_valid}, 32'h0);
        @(negedge clk);
        #1;
        chk(out_valid == 1'b1, "R6", "valid after two edges", {31'h0, out_valid}, 32'h1);
        chk(out_rgb == e, "R6", "latency pixel colour", {8'h0, out_rgb}, {8'h0, e});
        @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R6", "drained", {31'h0, out_valid}, 32'h0);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R7 watchdog: cycles %0d expected below %0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    initial begin
        rst       = 1'b1;
        in_valid  = 1'b0;
        in_index  = '0;
        in_ctrl   = '0;
        in_direct = '0;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_latency();
        t_direct();
        t_palette();
        t_throughput();
        t_mixed(2, 3, "R9");
        t_mixed(0, 1, "R7");
        t_mixed(3, 2, "R9");
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule